// File: doc/BRIEF.md
# Wide-Word Multi-Unit Issue Controller

This block reads a program of wide instruction words from an instruction memory and starts up to four independent execution units from a single word. The four units are a weight loader (memory to on-chip SRAM), a weight setter (SRAM to the compute array registers), a matrix engine (activation load, multiply-accumulate, result store) and a pooling engine (activation load, pooling or normalisation, result store).

Each word carries a per-unit enable mask, an end flag and one payload field per unit. The controller has two stages. The first stage reads the word at the program counter and decodes it. The second stage registers the selected payloads and sends a one-cycle start pulse to each selected unit.

Program flow is straight-line: the counter only ever steps by one. The hardware does no dependency checking between units; the compiler must order dependent work. The one interlock the controller keeps is structural. A word waits at decode until every unit it names is idle and is not being started in that same cycle. A word with an empty mask and the end flag set stops the program.

Top module: `wide_issue_dispatch`

## Requirements
- R1: While reset is held and on release, `imem_addr` is 0, `unit_start` is 0, every `unit_arg` field is 0 and `halted` is 0.
- R2: Word layout: unit u's payload is bits [u*F_W +: F_W] (u=0 weight load, 1 weight set, 2 matrix engine, 3 pooling engine). The enable mask is bits [4*F_W +: 4], with bit u selecting unit u. The end flag is the top bit. A word decoded in cycle d and issued at the next edge raises `unit_start[u]` for each masked unit in cycle d+1, with that unit's payload on its `unit_arg` field.
- R3: A word whose mask has several bits set starts all of those units in the same cycle.
- R4: A start is a single-cycle pulse, and a unit is never started while its `unit_busy` is high.
- R5: If any masked unit is busy, or is being started in the current cycle, the word waits at decode. `imem_addr` holds and no unit of that word is started until all of its units are free. A unit with busy time L restarted by the next word therefore starts L+2 cycles after its previous start.
- R6: Each issued word advances `imem_addr` by exactly one. There is no other change of flow. A word with an empty mask and a clear end flag starts nothing and still advances.
- R7: A word with an empty mask and the end flag set raises `halted` one cycle after it is decoded. `halted` stays high until reset, `imem_addr` stays frozen and no unit is started.
- R8: The end flag has no effect on a word whose mask is not empty; that word issues normally.
- R9: A unit's `unit_arg` field changes only in a cycle where that unit is started, and otherwise holds the last payload sent to it.
- R10: Words that name disjoint sets of idle units issue on consecutive cycles, one word per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | PC_W | Program counter, address to the instruction memory |
| imem_rdata | input | 1+4*(F_W+1) | Word at `imem_addr`, combinational read |
| unit_busy | input | 4 | Per-unit busy flags |
| unit_start | output | 4 | Per-unit one-cycle start pulses |
| unit_arg | output | 4*F_W | Per-unit payloads, unit u at [u*F_W +: F_W] |
| halted | output | 1 | Program has reached its end word |

## Verification
The assertions assume that a unit raises `unit_busy` only in the cycle after it has been started. They also assume that the word on `imem_rdata` depends only on `imem_addr`. The bench's unit models follow this: each model loads a per-program busy time on a start pulse and counts it down. The instruction memory is a fixed array read combinationally. Every program is terminated by an end word well before the counter could wrap.

// File: rtl/wid_pkg.sv
package wid_pkg;

   // Number of execution units addressed by one word
   localparam int UNITS = 4;

   // Unit slot order inside the word (payload position and mask bit)
   localparam int SLOT_WLOAD = 0;
   localparam int SLOT_WSET  = 1;
   localparam int SLOT_MAC   = 2;
   localparam int SLOT_POOL  = 3;

   function automatic int word_width(input int fw);
      return 1 + UNITS * (fw + 1);
   endfunction

endpackage

// File: rtl/wid_fetch.sv
module wid_fetch #(
   parameter int PC_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            advance,
   input  logic            halt_seen,
   output logic [PC_W-1:0] pc,
   output logic            halted
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc     <= '0;
         halted <= 1'b0;
      end else if (halt_seen) begin
         halted <= 1'b1;
      end else if (advance) begin
         pc <= pc + PC_W'(1);
      end
   end

endmodule

// File: rtl/wid_decode.sv
module wid_decode #(
   parameter int N = 4
) (
   input  logic         end_flag,
   input  logic [N-1:0] mask,
   input  logic [N-1:0] unit_busy,
   input  logic [N-1:0] unit_start,
   input  logic         halted,
   output logic         advance,
   output logic         halt_seen,
   output logic [N-1:0] fire
);

   logic is_end;
   logic conflict;

   always_comb begin
      is_end    = end_flag && (mask == '0);
      // a unit is unavailable while busy or while its start pulse is out
      conflict  = |(mask & (unit_busy | unit_start));
      advance   = !halted && !is_end && !conflict;
      halt_seen = !halted && is_end;
      fire      = advance ? mask : '0;
   end

endmodule

// File: rtl/wid_issue_lane.sv
module wid_issue_lane #(
   parameter int F_W      = 8,
   parameter bit ARG_HOLD = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fire,
   input  logic [F_W-1:0] arg_in,
   output logic           start,
   output logic [F_W-1:0] arg_out
);

   always_ff @(posedge clk) begin
      if (!rst_n) start <= 1'b0;
      else        start <= fire;
   end

   generate
      if (ARG_HOLD) begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)    arg_out <= '0;
            else if (fire) arg_out <= arg_in;
         end
      end else begin : g_pulse
         always_ff @(posedge clk) begin
            if (!rst_n)    arg_out <= '0;
            else           arg_out <= fire ? arg_in : '0;
         end
      end
   endgenerate

endmodule

// File: rtl/wide_issue_dispatch.sv
module wide_issue_dispatch
   import wid_pkg::*;
#(
   parameter int F_W      = 8,
   parameter int PC_W     = 6,
   parameter bit ARG_HOLD = 1'b1,
   localparam int IW      = 1 + UNITS * (F_W + 1),
   localparam int MASK_LSB = UNITS * F_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   output logic [PC_W-1:0]      imem_addr,
   input  logic [IW-1:0]        imem_rdata,
   input  logic [UNITS-1:0]     unit_busy,
   output logic [UNITS-1:0]     unit_start,
   output logic [UNITS*F_W-1:0] unit_arg,
   output logic                 halted
);

   generate
      if (F_W < 1) begin : g_bad_fw
         $error("wide_issue_dispatch: F_W must be at least 1");
      end
      if (PC_W < 1 || PC_W > 24) begin : g_bad_pcw
         $error("wide_issue_dispatch: PC_W must be within 1..24");
      end
      if (IW != word_width(F_W)) begin : g_bad_iw
         $error("wide_issue_dispatch: word width mismatch");
      end
   endgenerate

   logic             advance;
   logic             halt_seen;
   logic [UNITS-1:0] fire;

   wid_decode #(.N(UNITS)) u_decode (
      .end_flag   (imem_rdata[IW-1]),
      .mask       (imem_rdata[MASK_LSB +: UNITS]),
      .unit_busy  (unit_busy),
      .unit_start (unit_start),
      .halted     (halted),
      .advance    (advance),
      .halt_seen  (halt_seen),
      .fire       (fire)
   );

   wid_fetch #(.PC_W(PC_W)) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .halt_seen (halt_seen),
      .pc        (imem_addr),
      .halted    (halted)
   );

   generate
      for (genvar u = 0; u < UNITS; u++) begin : g_lane
         wid_issue_lane #(.F_W(F_W), .ARG_HOLD(ARG_HOLD)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (fire[u]),
            .arg_in  (imem_rdata[u*F_W +: F_W]),
            .start   (unit_start[u]),
            .arg_out (unit_arg[u*F_W +: F_W])
         );
      end
   endgenerate

endmodule

// File: rtl/wid_checker.sv
module wid_checker
   import wid_pkg::*;
#(
   parameter int F_W      = 8,
   parameter int PC_W     = 6,
   parameter bit ARG_HOLD = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [PC_W-1:0]      imem_addr,
   input logic [UNITS-1:0]     unit_busy,
   input logic [UNITS-1:0]     unit_start,
   input logic [UNITS*F_W-1:0] unit_arg,
   input logic                 halted
);

   generate
      for (genvar u = 0; u < UNITS; u++) begin : g_unit
         assert_no_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
            unit_start[u] |-> !unit_busy[u]);
         assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
            unit_start[u] |=> !unit_start[u]);
         if (ARG_HOLD) begin : g_hold
            assert_arg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
               !$stable(unit_arg[u*F_W +: F_W]) |-> unit_start[u]);
         end
      end
   endgenerate

   assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (imem_addr == $past(imem_addr)) ||
               (imem_addr == $past(imem_addr) + PC_W'(1)));

   assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   assert_quiet_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (unit_start == '0));

   assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(imem_addr));

endmodule

bind wide_issue_dispatch wid_checker #(
   .F_W(F_W), .PC_W(PC_W), .ARG_HOLD(ARG_HOLD)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .imem_addr  (imem_addr),
   .unit_busy  (unit_busy),
   .unit_start (unit_start),
   .unit_arg   (unit_arg),
   .halted     (halted)
);

// File: tb/wide_issue_dispatch_tb.sv
`timescale 1ns/1ps
module wide_issue_dispatch_tb;
   localparam int F_W   = 8;
   localparam int PC_W  = 6;
   localparam int U     = 4;
   localparam int IW    = 1 + U * (F_W + 1);
   localparam int DEPTH = 1 << PC_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [PC_W-1:0]  imem_addr;
   logic [IW-1:0]    imem_rdata;
   logic [IW-1:0]    mem [DEPTH];
   logic [U-1:0]     unit_busy, unit_start;
   logic [U*F_W-1:0] unit_arg;
   logic             halted;

   assign imem_rdata = mem[imem_addr];

   wide_issue_dispatch #(.F_W(F_W), .PC_W(PC_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .unit_busy(unit_busy), .unit_start(unit_start), .unit_arg(unit_arg),
      .halted(halted)
   );

   // unit models: busy for lat[u] cycles after each start
   int lat  [U];
   int bcnt [U];
   int cyc;
   always @(posedge clk) begin
      for (int u = 0; u < U; u++) begin
         if (!rst_n)             bcnt[u] <= 0;
         else if (unit_start[u]) bcnt[u] <= lat[u];
         else if (bcnt[u] > 0)   bcnt[u] <= bcnt[u] - 1;
      end
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end
   always_comb for (int u = 0; u < U; u++) unit_busy[u] = (bcnt[u] > 0);

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // program description
   logic [U-1:0]   pmask [DEPTH];
   logic           pend  [DEPTH];
   logic [F_W-1:0] parg  [DEPTH][U];
   int             plen;

   // expected schedule
   int             exp_cyc [U][DEPTH];
   logic [F_W-1:0] exp_arg [U][DEPTH];
   int             exp_n   [U];
   int             exp_halt;

   function automatic logic [IW-1:0] mk_word(input int k);
      return {pend[k], pmask[k], parg[k][3], parg[k][2], parg[k][1], parg[k][0]};
   endfunction

   task automatic load_and_model();
      int s_prev;
      int last [U];
      for (int k = 0; k < DEPTH; k++) mem[k] = {1'b1, {(IW-1){1'b0}}};
      pmask[plen] = '0; pend[plen] = 1'b1;
      for (int u = 0; u < U; u++) parg[plen][u] = '0;
      for (int k = 0; k <= plen; k++) mem[k] = mk_word(k);
      s_prev = 0;
      for (int u = 0; u < U; u++) begin exp_n[u] = 0; last[u] = -1000; end
      for (int k = 0; k <= plen; k++) begin
         if (pend[k] && pmask[k] == '0) begin
            exp_halt = s_prev + 1;   // R7: halted one cycle after decode
            break;
         end else begin
            int s;
            s = s_prev + 1;
            for (int u = 0; u < U; u++)
               if (pmask[k][u] && last[u] + lat[u] + 2 > s) s = last[u] + lat[u] + 2;
            for (int u = 0; u < U; u++)
               if (pmask[k][u]) begin
                  exp_cyc[u][exp_n[u]] = s;
                  exp_arg[u][exp_n[u]] = parg[k][u];
                  exp_n[u]++;
                  last[u] = s;
               end
            s_prev = s;
         end
      end
   endtask

   task automatic run_prog(input string req);
      int got [U];
      int halt_at;
      load_and_model();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int u = 0; u < U; u++) got[u] = 0;
      halt_at = -1;
      for (int t = 0; t < 1000; t++) begin
         @(negedge clk);
         for (int u = 0; u < U; u++) begin
            if (unit_start[u]) begin
               chk(!unit_busy[u], "R4", $sformatf("start while busy unit %0d", u),
                   unit_busy[u], 0);
               if (got[u] < exp_n[u]) begin
                  chk(cyc == exp_cyc[u][got[u]], req,
                      $sformatf("start cycle unit %0d #%0d", u, got[u]),
                      cyc, exp_cyc[u][got[u]]);
                  chk(unit_arg[u*F_W +: F_W] == exp_arg[u][got[u]], req,
                      $sformatf("payload unit %0d #%0d", u, got[u]),
                      unit_arg[u*F_W +: F_W], exp_arg[u][got[u]]);
               end
               got[u]++;
            end
         end
         if (halted) begin halt_at = cyc; break; end
      end
      chk(halt_at == exp_halt, "R7", "halt cycle", halt_at, exp_halt);
      chk(imem_addr == PC_W'(plen), "R6", "final address", imem_addr, plen);
      for (int u = 0; u < U; u++)
         chk(got[u] == exp_n[u], req, $sformatf("start count unit %0d", u),
             got[u], exp_n[u]);
      repeat (3) @(negedge clk);
      chk(halted && unit_start == '0, "R7", "quiet after halt",
          {halted, unit_start}, {1'b1, 4'h0});
   endtask

   task automatic clear_prog();
      for (int k = 0; k < DEPTH; k++) begin
         pmask[k] = '0; pend[k] = 1'b0;
         for (int u = 0; u < U; u++) parg[k][u] = '0;
      end
      for (int u = 0; u < U; u++) lat[u] = 0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      clear_prog();
      plen = 0;
      load_and_model();

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(imem_addr == '0 && unit_start == '0 && unit_arg == '0 && !halted, "R1",
          "reset outputs", {imem_addr, unit_start, halted}, 0);

      // R2 R3: one word starting all four units
      clear_prog();
      pmask[0] = 4'hF;
      parg[0][0] = 8'h11; parg[0][1] = 8'h22; parg[0][2] = 8'h33; parg[0][3] = 8'h44;
      plen = 1;
      run_prog("R2 R3");

      // R5: same unit back to back with busy time 5
      clear_prog();
      lat[0] = 5;
      pmask[0] = 4'b0001; parg[0][0] = 8'hA1;
      pmask[1] = 4'b0001; parg[1][0] = 8'hA2;
      pmask[2] = 4'b0011; parg[2][0] = 8'hA3; parg[2][1] = 8'hB3;
      plen = 3;
      run_prog("R5");

      // R10: disjoint units issue one word per cycle
      clear_prog();
      for (int k = 0; k < 4; k++) begin
         pmask[k] = 4'b0001 << k; parg[k][k] = 8'(8'h50 + k);
      end
      plen = 4;
      run_prog("R10");

      // R6 R8 R9: no-op word, end flag with nonzero mask, payload hold
      clear_prog();
      pmask[0] = 4'b0000; pend[0] = 1'b0;
      pmask[1] = 4'b0010; parg[1][1] = 8'hC7; parg[1][0] = 8'hEE;
      pmask[2] = 4'b0100; pend[2] = 1'b1; parg[2][2] = 8'h9D; parg[2][1] = 8'h01;
      plen = 3;
      run_prog("R6 R8");
      chk(unit_arg[0 +: F_W] == 8'h00, "R9", "unmasked payload untouched",
          unit_arg[0 +: F_W], 8'h00);
      chk(unit_arg[F_W +: F_W] == 8'hC7, "R9", "payload held after start",
          unit_arg[F_W +: F_W], 8'hC7);
      chk(unit_arg[2*F_W +: F_W] == 8'h9D, "R8", "end-flag word payload",
          unit_arg[2*F_W +: F_W], 8'h9D);

      // R7: program that is only an end word
      clear_prog();
      plen = 0;
      run_prog("R7");

      // constrained random programs
      for (int p = 0; p < 8; p++) begin
         clear_prog();
         plen = 10 + int'($urandom_range(0, 30));
         for (int u = 0; u < U; u++) lat[u] = int'($urandom_range(0, 4));
         for (int k = 0; k < plen; k++) begin
            pmask[k] = 4'($urandom_range(0, 15));
            if (pmask[k] == '0) pend[k] = 1'b0;
            else                pend[k] = 1'($urandom_range(0, 1));
            for (int u = 0; u < U; u++) parg[k][u] = 8'($urandom);
         end
         run_prog("R2 R3 R5 R10");
      end

      finish_run();
   end

endmodule